// File: doc/BRIEF.md
# Length-Prefixed Packet Memory-Access Decoder

This block sits behind a bulk-transfer byte endpoint and turns host packets into accesses on an internal 32-bit register and buffer bus. Every packet opens with an 8-byte little-endian header. The header holds a 16-bit length, then a 16-bit type code, then a 32-bit byte address. The length counts the four address bytes plus the payload but not the length and type fields themselves, so a whole packet spans length + 4 bytes. A packet is at most 512 bytes long.

A write packet stores its payload at consecutive byte addresses. The payload bytes are gathered into 32-bit words with byte strobes before they reach the bus. A read-request packet carries one 32-bit value, the wanted byte count plus 4. It is answered on the outbound byte stream with a response packet. That packet has the response type code, a length of count + 4, the echoed address, and then exactly the requested bytes. Packets that fail the checks are swallowed without touching the bus, and a sticky error flag is raised. Packets are handled one at a time, and the inbound stream is held off while a response is still leaving.

Top module: `tlv_mem_bridge`

## Requirements
- R1: Header bytes arrive in the order length (2 bytes), type (2 bytes), address (4 bytes), each little-endian; a packet occupies length + 4 bytes, and the byte that follows is taken as the next header.
- R2: Type 0x0100 with length between 4 and 508 writes payload byte k to byte address addr + k and leaves every other byte unchanged.
- R3: Write bytes go out as one bus write per touched 32-bit word, with bus_be_o bit L and bus_wdata_o bits 8L+7..8L used for byte address bits [1:0] = L, and with at least one strobe set.
- R4: Type 0x0200 with length 8, followed by a 32-bit value V (4 <= V <= 508), yields an outbound packet of V + 4 bytes: length V (2 bytes), type 0x8200 (bytes 0x00, 0x82), the request address, then the V - 4 bytes read from addr onward.
- R5: A read request with V = 4 yields only the 8-byte response header.
- R6: A packet with an unknown type, a length below 4, or a write length above 508 causes no bus access. Its remaining bytes (length - 4, or none when the length is below 4) are consumed, and err_o is set and stays set until reset.
- R7: A read request whose length field is not 8, or whose V is below 4 or above 508, produces no response and no bus access, and it sets err_o.
- R8: in_ready_o is low whenever a response byte is offered, and no bus write occurs during a response.
- R9: After reset, in_ready_o is 1, out_valid_o is 0, err_o is 0 and bus_req_o is 0.
- R10: While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o hold their values into the next cycle.
- R11: A write packet of length 4 (empty payload) performs no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Inbound packet byte |
| in_valid_i | input | 1 | Inbound byte valid |
| in_ready_o | output | 1 | Inbound byte accepted when high with valid |
| out_data_o | output | 8 | Response packet byte |
| out_valid_o | output | 1 | Response byte valid |
| out_ready_i | input | 1 | Response byte taken when high with valid |
| bus_req_o | output | 1 | Bus access this cycle |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | 32 | Word-aligned byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_be_o | output | 4 | Byte strobes |
| bus_rdata_i | input | 32 | Read data, valid the cycle after a read access |
| err_o | output | 1 | Sticky malformed-packet flag |

## Verification
Writes are swept over all four start alignments with payloads from zero to nine bytes. This separates the cases of a head and a tail inside one word, words crossed at either edge, and the empty packet. The result is checked against a byte shadow of the whole memory and against the expected count of bus writes. Reads are swept the same way, once with a free outbound stream and once with periodic backpressure. This shows whether word fetches restart at the right lane and whether bytes hold under stall. Each malformed packet kind is followed by a valid write, which tells a correct byte-count discard apart from loss of framing.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam logic [15:0] TYPE_WR    = 16'h0100;
  localparam logic [15:0] TYPE_RDREQ = 16'h0200;
  localparam logic [15:0] TYPE_RDRSP = 16'h8200;
  localparam int unsigned HDR_BYTES  = 8;

  typedef enum logic [2:0] {
    RX_HDR, RX_WR, RX_RDLEN, RX_DROP, RX_WAIT
  } rx_state_e;

  typedef enum logic [2:0] {
    TX_IDLE, TX_HDR, TX_FETCH, TX_LATCH, TX_SEND
  } tx_state_e;
endpackage

// File: rtl/tmb_rx.sv
module tmb_rx
  import tmb_pkg::*;
#(
  parameter int unsigned MAX_PKT = 512,
  parameter int unsigned CNT_W   = $clog2(MAX_PKT - HDR_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             tx_busy_i,
  output logic             wr_beat_o,
  output logic [7:0]       wr_byte_o,
  output logic [31:0]      wr_addr_o,
  output logic             wr_last_o,
  output logic             rd_start_o,
  output logic [31:0]      rd_addr_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             err_o
);
  localparam logic [15:0] MAX_LEN = 16'(MAX_PKT - 4);

  rx_state_e   state_q;
  logic [2:0]  idx_q;
  logic [55:0] hdr_q;
  logic [23:0] val_q;
  logic [15:0] cnt_q;
  logic [31:0] cur_q;
  logic [31:0] addr_q;
  logic        err_q;

  logic [63:0] hdr_full;
  logic [15:0] h_len, h_type;
  logic [31:0] h_addr, rd_val;
  logic        accept, is_wr, is_rd, val_ok;
  logic [15:0] drop_n;

  assign in_ready_o = (state_q != RX_WAIT);
  assign accept     = in_valid_i && in_ready_o;

  assign hdr_full = {in_data_i, hdr_q};
  assign h_len    = hdr_full[15:0];
  assign h_type   = hdr_full[31:16];
  assign h_addr   = hdr_full[63:32];
  assign is_wr    = (h_type == TYPE_WR) && (h_len >= 16'd4) && (h_len <= MAX_LEN);
  assign is_rd    = (h_type == TYPE_RDREQ) && (h_len == 16'd8);
  assign drop_n   = (h_len < 16'd4) ? 16'd0 : h_len - 16'd4;

  assign rd_val   = {in_data_i, val_q};
  assign val_ok   = (rd_val >= 32'd4) && (rd_val <= 32'(MAX_LEN));

  assign wr_beat_o  = accept && (state_q == RX_WR);
  assign wr_byte_o  = in_data_i;
  assign wr_addr_o  = cur_q;
  assign wr_last_o  = (cnt_q == 16'd1);
  assign rd_start_o = accept && (state_q == RX_RDLEN) && (idx_q == 3'd3) && val_ok;
  assign rd_addr_o  = addr_q;
  assign rd_cnt_o   = CNT_W'(rd_val - 32'd4);
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_HDR;
      idx_q   <= '0;
      hdr_q   <= '0;
      val_q   <= '0;
      cnt_q   <= '0;
      cur_q   <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        RX_HDR: if (accept) begin
          hdr_q[8*idx_q +: 8] <= in_data_i;
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'd7) begin
            idx_q <= '0;
            if (is_wr) begin
              if (h_len != 16'd4) begin
                state_q <= RX_WR;
                cnt_q   <= h_len - 16'd4;
                cur_q   <= h_addr;
              end
            end else if (is_rd) begin
              state_q <= RX_RDLEN;
              addr_q  <= h_addr;
            end else begin
              err_q <= 1'b1;
              if (drop_n != 16'd0) begin
                state_q <= RX_DROP;
                cnt_q   <= drop_n;
              end
            end
          end
        end
        RX_WR: if (accept) begin
          cur_q <= cur_q + 32'd1;
          cnt_q <= cnt_q - 16'd1;
          if (cnt_q == 16'd1) state_q <= RX_HDR;
        end
        RX_RDLEN: if (accept) begin
          if (idx_q != 3'd3) val_q[8*idx_q[1:0] +: 8] <= in_data_i;
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'd3) begin
            idx_q <= '0;
            if (val_ok) state_q <= RX_WAIT;
            else begin
              state_q <= RX_HDR;
              err_q   <= 1'b1;
            end
          end
        end
        RX_DROP: if (accept) begin
          cnt_q <= cnt_q - 16'd1;
          if (cnt_q == 16'd1) state_q <= RX_HDR;
        end
        RX_WAIT: if (!tx_busy_i) state_q <= RX_HDR;
        default: state_q <= RX_HDR;
      endcase
    end
  end
endmodule

// File: rtl/tmb_wpack.sv
module tmb_wpack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        beat_i,
  input  logic [7:0]  byte_i,
  input  logic [31:0] addr_i,
  input  logic        last_i,
  output logic        req_o,
  output logic [31:0] addr_o,
  output logic [31:0] data_o,
  output logic [3:0]  be_o
);
  logic [31:0] acc_data;
  logic [3:0]  acc_be;
  logic [31:0] nxt_data;
  logic [3:0]  nxt_be;
  logic [1:0]  lane;

  assign lane = addr_i[1:0];

  always_comb begin
    nxt_data = acc_data;
    nxt_data[8*lane +: 8] = byte_i;
    nxt_be = acc_be | (4'b0001 << lane);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_data <= '0;
      acc_be   <= '0;
      req_o    <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
      be_o     <= '0;
    end else begin
      req_o <= 1'b0;
      if (beat_i) begin
        if (last_i || lane == 2'd3) begin
          req_o    <= 1'b1;
          addr_o   <= {addr_i[31:2], 2'b00};
          data_o   <= nxt_data;
          be_o     <= nxt_be;
          acc_data <= '0;
          acc_be   <= '0;
        end else begin
          acc_data <= nxt_data;
          acc_be   <= nxt_be;
        end
      end
    end
  end
endmodule

// File: rtl/tmb_tx.sv
module tmb_tx
  import tmb_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             rd_req_o,
  output logic [31:0]      rd_addr_o,
  input  logic [31:0]      rd_data_i
);
  tx_state_e        state_q;
  logic [2:0]       hidx_q;
  logic [31:0]      base_q, ca_q, word_q;
  logic [CNT_W-1:0] n_q, k_q;
  logic [15:0]      rsp_len;
  logic [7:0]       hdr_byte;
  logic             fire;

  assign rsp_len     = 16'(n_q) + 16'd4;
  assign busy_o      = (state_q != TX_IDLE);
  assign out_valid_o = (state_q == TX_HDR) || (state_q == TX_SEND);
  assign fire        = out_valid_o && out_ready_i;
  assign rd_req_o    = (state_q == TX_FETCH);
  assign rd_addr_o   = {ca_q[31:2], 2'b00};

  always_comb begin
    unique case (hidx_q)
      3'd0:    hdr_byte = rsp_len[7:0];
      3'd1:    hdr_byte = rsp_len[15:8];
      3'd2:    hdr_byte = TYPE_RDRSP[7:0];
      3'd3:    hdr_byte = TYPE_RDRSP[15:8];
      3'd4:    hdr_byte = base_q[7:0];
      3'd5:    hdr_byte = base_q[15:8];
      3'd6:    hdr_byte = base_q[23:16];
      default: hdr_byte = base_q[31:24];
    endcase
  end

  assign out_data_o = (state_q == TX_SEND) ? word_q[8*ca_q[1:0] +: 8] : hdr_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      hidx_q  <= '0;
      base_q  <= '0;
      ca_q    <= '0;
      word_q  <= '0;
      n_q     <= '0;
      k_q     <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (start_i) begin
          state_q <= TX_HDR;
          hidx_q  <= '0;
          base_q  <= addr_i;
          ca_q    <= addr_i;
          n_q     <= cnt_i;
          k_q     <= '0;
        end
        TX_HDR: if (fire) begin
          hidx_q <= hidx_q + 3'd1;
          if (hidx_q == 3'd7) state_q <= (n_q == '0) ? TX_IDLE : TX_FETCH;
        end
        TX_FETCH: state_q <= TX_LATCH;
        TX_LATCH: begin
          word_q  <= rd_data_i;
          state_q <= TX_SEND;
        end
        TX_SEND: if (fire) begin
          ca_q <= ca_q + 32'd1;
          k_q  <= k_q + CNT_W'(1);
          if ((k_q + CNT_W'(1)) == n_q) state_q <= TX_IDLE;
          else if (ca_q[1:0] == 2'd3)   state_q <= TX_FETCH;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlv_mem_bridge.sv
module tlv_mem_bridge
  import tmb_pkg::*;
#(
  parameter int unsigned MAX_PKT = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  in_data_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  output logic [7:0]  out_data_o,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [31:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  output logic [3:0]  bus_be_o,
  input  logic [31:0] bus_rdata_i,
  output logic        err_o
);
  localparam int unsigned CNT_W = $clog2(MAX_PKT - HDR_BYTES + 1);

  logic             tx_busy, wr_beat, wr_last, rd_start;
  logic [7:0]       wr_byte;
  logic [31:0]      wr_baddr, rd_addr;
  logic [CNT_W-1:0] rd_cnt;
  logic             wp_req, tx_req;
  logic [31:0]      wp_addr, wp_data, tx_addr;
  logic [3:0]       wp_be;

  tmb_rx #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .tx_busy_i(tx_busy),
    .wr_beat_o(wr_beat), .wr_byte_o(wr_byte), .wr_addr_o(wr_baddr), .wr_last_o(wr_last),
    .rd_start_o(rd_start), .rd_addr_o(rd_addr), .rd_cnt_o(rd_cnt),
    .err_o(err_o)
  );

  tmb_wpack u_wpack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .beat_i(wr_beat), .byte_i(wr_byte), .addr_i(wr_baddr), .last_i(wr_last),
    .req_o(wp_req), .addr_o(wp_addr), .data_o(wp_data), .be_o(wp_be)
  );

  tmb_tx #(.CNT_W(CNT_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(rd_start), .addr_i(rd_addr), .cnt_i(rd_cnt),
    .busy_o(tx_busy),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .rd_req_o(tx_req), .rd_addr_o(tx_addr), .rd_data_i(bus_rdata_i)
  );

  // rx stalls during a response, so the two bus sources never overlap
  assign bus_req_o   = wp_req | tx_req;
  assign bus_we_o    = wp_req;
  assign bus_addr_o  = wp_req ? wp_addr : tx_addr;
  assign bus_wdata_o = wp_data;
  assign bus_be_o    = wp_req ? wp_be : 4'hf;
endmodule

// File: rtl/tmb_checker.sv
module tmb_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_o,
  input logic [7:0] out_data_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic       bus_req_o,
  input logic       bus_we_o,
  input logic [3:0] bus_be_o,
  input logic       err_o
);
  a_r8_stall_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r8_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(bus_req_o && bus_we_o));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r3_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o) |-> (bus_be_o != 4'h0));
endmodule

bind tlv_mem_bridge tmb_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ready_o(in_ready_o),
  .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_be_o(bus_be_o), .err_o(err_o)
);

// File: tb/sim_tlv_mem_bridge.sv
module sim_tlv_mem_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        bus_req, bus_we, err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;

  logic [31:0] mem [0:255];
  logic [7:0]  shadow [0:1023];
  logic [7:0]  rsp [0:1023];
  int          rcount = 0;
  int          wcnt = 0, rdcnt = 0;
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0, r8_viol = 0;
  logic        bp_en = 1'b0;
  logic        finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlv_mem_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_be_o(bus_be), .bus_rdata_i(bus_rdata),
    .err_o(err)
  );

  initial begin
    for (int w = 0; w < 256; w++)
      for (int l = 0; l < 4; l++) begin
        mem[w][8*l +: 8] = 8'((w*4 + l) * 7 + 3);
        shadow[w*4 + l]  = 8'((w*4 + l) * 7 + 3);
      end
    bus_rdata = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= bp_en ? (cyc % 3 != 1) : 1'b1;
    if (bus_req) begin
      if (bus_we) begin
        wcnt <= wcnt + 1;
        for (int l = 0; l < 4; l++)
          if (bus_be[l]) mem[bus_addr[9:2]][8*l +: 8] <= bus_wdata[8*l +: 8];
      end else begin
        rdcnt <= rdcnt + 1;
        bus_rdata <= mem[bus_addr[9:2]];
      end
    end
  end

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      rsp[rcount] = out_data;
      rcount = rcount + 1;
    end
    if (out_valid && in_ready) r8_viol = r8_viol + 1;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [15:0] len, input logic [15:0] typ, input logic [31:0] a);
    put(len[7:0]); put(len[15:8]); put(typ[7:0]); put(typ[15:8]);
    put(a[7:0]); put(a[15:8]); put(a[23:16]); put(a[31:24]);
  endtask

  task automatic mem_cmp(input string tag);
    int bad_i;
    bad_i = -1;
    for (int i = 0; i < 1024; i++)
      if (bad_i < 0 && mem[i/4][8*(i%4) +: 8] !== shadow[i]) bad_i = i;
    if (bad_i < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, {24'd0, mem[bad_i/4][8*(bad_i%4) +: 8]}, {24'd0, shadow[bad_i]});
  endtask

  task automatic do_write(input int a, input int n, input int seed, input string tag);
    int w0, exp_w;
    w0 = wcnt;
    send_hdr(16'(n + 4), 16'h0100, 32'(a));
    for (int k = 0; k < n; k++) begin
      put(8'(seed + k * 29));
      shadow[a + k] = 8'(seed + k * 29);
    end
    repeat (4) @(negedge clk);
    mem_cmp(tag);
    exp_w = (n == 0) ? 0 : ((a % 4) + n + 3) / 4;
    chk((wcnt - w0) == exp_w, (n == 0) ? "R11 empty write bus count" : "R3 bus write count",
        32'(wcnt - w0), 32'(exp_w));
  endtask

  task automatic do_read(input int a, input int n, input string tag);
    logic [7:0] e;
    int bad_k, tot;
    logic [31:0] v;
    rcount = 0;
    v = 32'(n + 4);
    send_hdr(16'd8, 16'h0200, 32'(a));
    put(v[7:0]); put(v[15:8]); put(v[23:16]); put(v[31:24]);
    tot = n + 8;
    for (int t = 0; t < 4000 && !(rcount >= tot && in_ready); t++) @(negedge clk);
    repeat (5) @(negedge clk);
    bad_k = -1;
    for (int k = 0; k < tot; k++) begin
      case (k)
        0: e = v[7:0];
        1: e = v[15:8];
        2: e = 8'h00;
        3: e = 8'h82;
        4: e = 8'(a);
        5: e = 8'(a >> 8);
        6: e = 8'(a >> 16);
        7: e = 8'(a >> 24);
        default: e = shadow[a + k - 8];
      endcase
      if (bad_k < 0 && rsp[k] !== e) bad_k = k;
    end
    chk(rcount == tot, tag, 32'(rcount), 32'(tot));
    if (bad_k >= 0) chk(1'b0, tag, {24'd0, rsp[bad_k]}, 32'(bad_k));
    else chk(1'b1, tag, 0, 0);
  endtask

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && err == 1'b0 && bus_req == 1'b0,
        "R9 reset state", {28'd0, in_ready, out_valid, err, bus_req}, 32'h8);

    // R1 R2 R3 R11: alignment x length sweep, packets back to back
    for (int off = 0; off < 4; off++)
      for (int n = 0; n < 10; n++)
        do_write(64 + off + 16 * n, n, off * 40 + n, "R1 R2 write sweep");

    // R4 R5 R10: reads over written and untouched regions, with and without stall
    for (int pass = 0; pass < 2; pass++) begin
      bp_en = (pass == 1);
      for (int off = 0; off < 4; off++)
        for (int n = 0; n < 10; n++)
          do_read(64 + off + 16 * n - 2 * pass, n,
                  (n == 0) ? "R5 empty read" : (pass == 1 ? "R10 R4 read stalled" : "R4 read"));
    end
    bp_en = 1'b0;
    chk(err == 1'b0, "R6 no error on valid packets", {31'd0, err}, 0);
    chk(r8_viol == 0, "R8 input stalled during response", 32'(r8_viol), 0);

    // R6: unknown type, drop 6 bytes
    w0 = wcnt; r0 = rdcnt;
    send_hdr(16'd10, 16'h0300, 32'd200);
    for (int k = 0; k < 6; k++) put(8'hee);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R6 unknown type sets err", {31'd0, err}, 1);
    chk(wcnt == w0 && rdcnt == r0, "R6 unknown type no bus", 32'(wcnt - w0 + rdcnt - r0), 0);
    do_write(300, 5, 77, "R6 framing after unknown type");

    // R6: length below 4, header only
    w0 = wcnt;
    send_hdr(16'd2, 16'h0100, 32'd400);
    repeat (3) @(negedge clk);
    chk(wcnt == w0, "R6 short length no bus", 32'(wcnt - w0), 0);
    do_write(401, 3, 11, "R6 framing after short length");

    // R6: write length above limit, drop 596 bytes
    w0 = wcnt;
    send_hdr(16'd600, 16'h0100, 32'd500);
    for (int k = 0; k < 596; k++) put(8'(k));
    repeat (3) @(negedge clk);
    chk(wcnt == w0, "R6 long length no bus", 32'(wcnt - w0), 0);
    mem_cmp("R6 long length memory unchanged");
    do_write(503, 6, 5, "R6 framing after long length");

    // R7: read request with wrong length field, drop 8 bytes
    rcount = 0; r0 = rdcnt;
    send_hdr(16'd12, 16'h0200, 32'd100);
    for (int k = 0; k < 8; k++) put(8'h04);
    repeat (10) @(negedge clk);
    chk(rcount == 0 && rdcnt == r0, "R7 bad read length no response", 32'(rcount), 0);

    // R7: requested value below 4 and above 508
    send_hdr(16'd8, 16'h0200, 32'd100);
    put(8'd2); put(8'd0); put(8'd0); put(8'd0);
    repeat (10) @(negedge clk);
    chk(rcount == 0 && rdcnt == r0, "R7 value below 4 no response", 32'(rcount), 0);
    send_hdr(16'd8, 16'h0200, 32'd100);
    put(8'h58); put(8'h02); put(8'd0); put(8'd0);
    repeat (10) @(negedge clk);
    chk(rcount == 0 && rdcnt == r0, "R7 value above 508 no response", 32'(rcount), 0);
    chk(err == 1'b1, "R7 err stays set", {31'd0, err}, 1);
    do_read(503, 6, "R7 framing after bad reads");
    chk(r8_viol == 0, "R8 input stalled during response", 32'(r8_viol), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule